// File: doc/BRIEF.md
# Dual-Rate Clock-Enable Generator

This block runs on the oscillator clock and produces single-cycle enable pulses. A processor core and six peripherals use these pulses as their "advance one cycle" strobes, so no derived clock is needed. The core strobe uses a fast interval of 6 oscillator periods or a standard interval of 12. The six peripheral strobes cover timer 0, timer 1, timer 2, the serial port's shift and fixed-rate modes, the counter array and the watchdog. Each peripheral strobe can follow the fast interval or stay at the standard one.

One 8-bit control register, at special-function-register address 8Fh, selects the rates. A global fast-mode bit decides the core rate and also arms the per-peripheral bits. While the global bit is clear, every peripheral strobe stays at the standard interval, whatever its own bit holds. Each divider picks up a new rate only when its current interval completes. This keeps any strobe interval from being cut short or stretched by a rate change.

Top module: `dual_rate_tick_gen`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x00. Every strobe then repeats every 12 oscillator cycles, and each strobe's first pulse comes in the 12th cycle after reset is released.
- R2: The core strobe `cpu_tick` repeats every 6 cycles while control bit 0 (global fast mode) is 1, and every 12 cycles while it is 0.
- R3: While bit 0 is 1, a peripheral strobe repeats every 6 cycles if its select bit is 0 and every 12 cycles if its select bit is 1.
- R4: While bit 0 is 0, all peripheral select bits are ignored, and every peripheral strobe repeats every 12 cycles.
- R5: Each strobe is high for exactly one clock cycle and pulses once per interval.
- R6: A rate change takes effect only after the interval in progress completes. That interval keeps the length it started with, and the following interval uses the new rate.
- R7: The select bits are mapped as follows: bit 1 controls timer 0, bit 2 timer 1, bit 3 timer 2, bit 4 the serial shift/fixed-rate strobe, bit 5 the counter array and bit 6 the watchdog.
- R8: Bit 7 ignores writes and reads 0. Bits 6..0 read back as written.
- R9: The register changes only on a write strobe whose address is 8Fh. A read at 8Fh returns the register, and a read at any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data (combinational on address) |
| cpu_tick | output | 1 | Core machine-cycle strobe |
| t0_tick | output | 1 | Timer 0 strobe |
| t1_tick | output | 1 | Timer 1 strobe |
| t2_tick | output | 1 | Timer 2 strobe |
| ser_tick | output | 1 | Serial shift/fixed-rate mode strobe |
| arr_tick | output | 1 | Counter array strobe |
| wdg_tick | output | 1 | Watchdog strobe |

## Verification
The hardest case to reach from the ports is a rate change that lands partway through an interval. The change must leave that interval at its old length and alter only the next one. The bench writes the register at several offsets from the last strobe, including on the cycle just before a boundary, and toggles the global bit back and forth. A per-cycle behavioural model tracks each strobe's phase and active interval, and the bench compares every strobe and the read data against that model on every clock.

// File: rtl/tick_gen_pkg.sv
// Package: shared constants for the dual-rate clock-enable generator.
// Assumes channel 0 is the core and channels 1..6 follow the register bit order.
package tick_gen_pkg;
    localparam int unsigned CTRL_W      = 8;
    localparam int unsigned GLOBAL_BIT  = 0;
    localparam int unsigned RSVD_BIT    = 7;
    localparam int unsigned NUM_PERIPH  = 6;
    localparam logic [7:0]  CTRL_ADDR_D = 8'h8F;
endpackage

// File: rtl/rate_ctrl_reg.sv
// Module: rate_ctrl_reg
// Holds the rate-select register and serves reads on the special-function bus.
// Assumes the write strobe is one cycle per access; the reserved top bit is kept at 0.
module rate_ctrl_reg
    import tick_gen_pkg::*;
#(
    parameter logic [7:0] ADDR = CTRL_ADDR_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [7:0]        addr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output logic [CTRL_W-1:0] ctrl
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              hit;

    // Address decode shared by read and write.
    assign hit = (addr == ADDR);

    // Register update: only on a qualified write; the reserved bit is forced low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr && hit) begin
            ctrl_q <= wdata & ~(CTRL_W'(1) << RSVD_BIT);
        end
    end

    // Read mux: register at its address, zero elsewhere.
    always_comb begin
        rdata = hit ? ctrl_q : '0;
    end

    assign ctrl = ctrl_q;

    // R9
    hold_unless_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && hit) |=> $stable(ctrl_q));
endmodule

// File: rtl/tick_divider.sv
// Module: tick_divider
// Counts oscillator cycles and emits a one-cycle strobe at the end of each interval.
// The rate request is sampled only on the wrap cycle, so an interval never changes
// length once started. Assumes FAST_DIV >= 2 and SLOW_DIV > FAST_DIV.
module tick_divider #(
    parameter int unsigned SLOW_DIV = 12,
    parameter int unsigned FAST_DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_req,
    output logic tick
);
    localparam int unsigned CNT_W = $clog2(SLOW_DIV);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             fast_q;
    logic             wrap;

    // End-of-interval detect for the rate currently in force.
    assign wrap = (cnt_q == (fast_q ? FAST_LAST : SLOW_LAST));
    assign tick = wrap;

    // Counter and active rate: the new rate is latched only at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fast_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            fast_q <= fast_req;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R5
    single_cycle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R6
    rate_held_mid_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(fast_q));
    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SLOW_LAST);
endmodule

// File: rtl/dual_rate_tick_gen.sv
// Module: dual_rate_tick_gen (top)
// Builds the core strobe and six peripheral strobes from one control register.
// The global fast bit arms the per-peripheral bits; a set peripheral bit keeps
// that peripheral at the standard rate. Assumes one oscillator clock domain.
module dual_rate_tick_gen
    import tick_gen_pkg::*;
#(
    parameter int unsigned SLOW_DIV = 12,
    parameter int unsigned FAST_DIV = 6,
    parameter logic [7:0]  ADDR     = CTRL_ADDR_D
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sfr_wr,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    output logic       cpu_tick,
    output logic       t0_tick,
    output logic       t1_tick,
    output logic       t2_tick,
    output logic       ser_tick,
    output logic       arr_tick,
    output logic       wdg_tick
);
    logic [CTRL_W-1:0]     ctrl;
    logic                  global_fast;
    logic [NUM_PERIPH-1:0] per_req;
    logic [NUM_PERIPH-1:0] per_tick;

    rate_ctrl_reg #(.ADDR(ADDR)) reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (sfr_wr),
        .addr  (sfr_addr),
        .wdata (sfr_wdata),
        .rdata (sfr_rdata),
        .ctrl  (ctrl)
    );

    assign global_fast = ctrl[GLOBAL_BIT];

    // Core divider: follows the global bit directly.
    tick_divider #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) cpu_div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_req (global_fast),
        .tick     (cpu_tick)
    );

    // Peripheral dividers: fast only when armed globally and not held back locally.
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_per
        assign per_req[i] = global_fast & ~ctrl[GLOBAL_BIT + 1 + i];
        tick_divider #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) div_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .fast_req (per_req[i]),
            .tick     (per_tick[i])
        );
    end

    // R7: strobe order matches register bits 1..6.
    assign t0_tick  = per_tick[0];
    assign t1_tick  = per_tick[1];
    assign t2_tick  = per_tick[2];
    assign ser_tick = per_tick[3];
    assign arr_tick = per_tick[4];
    assign wdg_tick = per_tick[5];

    // R8
    rsvd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr |=> (sfr_rdata[RSVD_BIT] == 1'b0));
endmodule

// File: tb/dual_rate_tick_gen_tb.sv
// Bench: behavioural per-cycle model of phase and interval per strobe, compared every clock.
module dual_rate_tick_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       cpu_tick, t0_tick, t1_tick, t2_tick, ser_tick, arr_tick, wdg_tick;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // model state
    int   ph  [7];
    int   per [7];
    logic [7:0] mctrl = 8'h00;

    always #2.5 clk = ~clk;   // 200 MHz

    dual_rate_tick_gen dut_i (
        .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .cpu_tick(cpu_tick),
        .t0_tick(t0_tick), .t1_tick(t1_tick), .t2_tick(t2_tick),
        .ser_tick(ser_tick), .arr_tick(arr_tick), .wdg_tick(wdg_tick)
    );

    function automatic int req_period(int ch, logic [7:0] c);
        if (ch == 0) return c[0] ? 6 : 12;
        return (c[0] && !c[ch]) ? 6 : 12;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model: advance phases, then apply a qualified write (R9, R8).
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            mctrl = 8'h00;
            for (int c = 0; c < 7; c++) begin ph[c] = 0; per[c] = 12; end
        end else begin
            for (int c = 0; c < 7; c++) begin
                if (ph[c] == per[c] - 1) begin
                    ph[c] = 0;
                    per[c] = req_period(c, mctrl);   // R6: new rate only at boundary
                end else begin
                    ph[c]++;
                end
            end
            if (sfr_wr && sfr_addr == 8'h8F) mctrl = {1'b0, sfr_wdata[6:0]};
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic [6:0] act;
            act = {wdg_tick, arr_tick, ser_tick, t2_tick, t1_tick, t0_tick, cpu_tick};
            check("R2 R5 R6 cpu_tick", int'(act[0]), int'(ph[0] == per[0] - 1));
            for (int c = 1; c < 7; c++)
                check(mctrl[0] ? "R3 R7 peripheral tick" : "R4 peripheral tick",
                      int'(act[c]), int'(ph[c] == per[c] - 1));
            check("R9 sfr_rdata", int'(sfr_rdata),
                  int'((sfr_addr == 8'h8F) ? mctrl : 8'h00));
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0; sfr_addr = 8'h8F;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            finish_run();
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        sfr_addr = 8'h8F;
        // R1: reset value and first strobe in the 12th cycle
        @(negedge clk);
        check("R1 reset rdata", int'(sfr_rdata), 0);
        idle(10);
        check("R1 first cpu_tick", int'(cpu_tick), 1);
        check("R1 first wdg_tick", int'(wdg_tick), 1);
        idle(30);
        // R4: peripheral bits ignored while global bit clear
        wr(8'h8F, 8'h00);
        idle(40);
        wr(8'h8F, 8'h7E);
        idle(40);
        // R2 R3: global fast, all peripherals fast
        wr(8'h8F, 8'h01);
        idle(50);
        // R7: one peripheral at a time held back
        for (int b = 1; b < 7; b++) begin
            wr(8'h8F, 8'h01 | (8'h01 << b));
            idle(30 + b);
        end
        // R3: alternating pattern
        wr(8'h8F, 8'h55);
        idle(37);
        wr(8'h8F, 8'h2B);
        idle(29);
        // R8: reserved bit
        wr(8'h8F, 8'hFF);
        @(negedge clk);
        check("R8 reserved bit reads 0", int'(sfr_rdata), 8'h7F);
        idle(20);
        // R9: other address ignored, reads zero there
        wr(8'h8E, 8'h00);
        @(negedge clk);
        check("R9 write elsewhere ignored", int'(sfr_rdata), 8'h7F);
        sfr_addr = 8'h10;
        @(negedge clk);
        check("R9 read elsewhere zero", int'(sfr_rdata), 0);
        sfr_addr = 8'h8F;
        // R6: toggle rate at many offsets within an interval
        for (int k = 0; k < 14; k++) begin
            wr(8'h8F, (k % 2) ? 8'h01 : 8'h00);
            idle(k);
        end
        for (int k = 0; k < 14; k++) begin
            wr(8'h8F, (k % 2) ? 8'h03 : 8'h41);
            idle(k % 5);
        end
        idle(60);
        // R1: reset mid-run returns to standard rate
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after re-reset", int'(sfr_rdata), 0);
        idle(50);
        finish_run();
    end
endmodule